// File: doc/BRIEF.md
# Command transaction sequencer

This block runs request/reply transactions with a power-management controller over a byte-wide link. It accepts request descriptors into a short queue. Each descriptor holds a tag, an opcode, a total byte count (opcode included) and a flag that marks a request whose answer arrives later as interrupt data. For the request at the head of the queue, the sequencer asks an external length table how many bytes the opcode sends and how many it gets back. It then pushes the opcode and data bytes onto the link and gathers the reply bytes into a 32-byte receive buffer. The requester supplies the data bytes on demand through a tag/index fetch port.

When the controller flags an interrupt, the sequencer answers it between transactions. It sends the acknowledge opcode and reads a length-prefixed payload into the same buffer. Completion is reported by a one-cycle done pulse that carries the tag, the reply length and an error bit. Interrupt payloads get their own pulse. A link that stops responding aborts the transaction that is waiting on it.

Top module: `cmd_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1 and `link_go`, `done` and `int_done` are 0. With no pending interrupt and an empty queue, no link transfer starts.
- R2: For an opcode whose send count is N ≥ 0, and a request whose byte count is N+1, the link carries the opcode first. It then carries data bytes 1..N in index order, each fetched through `dat_tag`/`dat_idx`.
- R3: For an opcode whose send count is -1 (0xFF), the link carries the opcode, then one length byte equal to the byte count minus one, then the data bytes in order.
- R4: A request whose byte count differs from N+1 for a fixed send count N is dropped without any link transfer. It completes with `done`=1, `done_err`=1 and `done_len`=0.
- R5: For a fixed reply count M > 0, the sequencer performs exactly M receive transfers after the last send. It stores byte k at buffer address k and completes with `done_len`=M.
- R6: For a reply count of -1, the first received byte is the reply length L. The next L bytes go to buffer addresses 0..L-1, and `done_len`=L.
- R7: For a reply count of 0, the request completes with `done_len`=0 and `done_err`=0 right after its last byte is sent, with no receive transfer.
- R8: When an interrupt notification (`irq_note`) is pending and the block is idle, it sends the acknowledge opcode (default 0x78) before any queued request. It then reads a length-prefixed payload and reports its byte count on `int_len` with `int_done`.
- R9: An interrupt payload length above 32 sets `int_err`. Only the first 32 payload bytes are stored, and later bytes never overwrite earlier addresses.
- R10: A request with `req_defer`=1 and reply count 0 produces no `done` after sending and is parked. Another deferred request at the head waits while one is parked. An interrupt payload whose first byte has bit 4 set completes the parked tag with `done_len` equal to the payload length minus one.
- R11: If the link does not answer within `TIMEOUT_CYC` cycles of a transfer start, the transaction aborts. A request completes with `done_err`=1, an interrupt read completes with `int_err`=1, and the block returns to idle and serves later requests normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request descriptor offered |
| req_ready | output | 1 | Queue has room |
| req_tag | input | TAG_W | Requester's tag for the request |
| req_op | input | 8 | Opcode |
| req_cnt | input | CNT_W | Total bytes including the opcode |
| req_defer | input | 1 | Reply comes later as interrupt data |
| lut_op | output | 8 | Opcode presented to the length table |
| lut_send | input | 8 | Signed send count, -1 = length byte |
| lut_reply | input | 8 | Signed reply count, -1 = length byte |
| dat_tag | output | TAG_W | Tag of the request being sent |
| dat_idx | output | CNT_W | Index of the data byte wanted |
| dat_byte | input | 8 | Data byte at `dat_tag`/`dat_idx` |
| link_go | output | 1 | Start one link transfer (pulse) |
| link_send | output | 1 | 1 = send `link_tx`, 0 = receive |
| link_tx | output | 8 | Byte to send |
| link_done | input | 1 | Transfer finished (pulse) |
| link_rx | input | 8 | Byte received |
| irq_note | input | 1 | Interrupt notification pulse |
| done | output | 1 | Request completion pulse |
| done_tag | output | TAG_W | Tag of the completed request |
| done_len | output | 8 | Reply length |
| done_err | output | 1 | Rejected or aborted |
| int_done | output | 1 | Interrupt payload read complete |
| int_len | output | 8 | Payload byte count |
| int_err | output | 1 | Payload length above 32, or abort |
| rd_addr | input | 5 | Receive buffer read address |
| rd_byte | output | 8 | Receive buffer byte |

## Verification
On every cycle the assertions check the ordering rules:
- an idle block with a pending notification issues the acknowledge opcode next;
- a rejected request pulses an error completion without starting the link;
- a parked deferred reply keeps the next deferred request off the link;
- an empty, quiet block stays silent;
- any payload length above 32 carries the error bit.

The exact byte sequences on the link, the placement of reply bytes in the buffer, the dropping of bytes beyond 32, deferred-reply delivery and recovery from a timeout are only visible through the bench's scenarios, which log the link traffic and read the buffer back.

// File: rtl/cmd_seq.sv
module cmd_seq #(
  parameter int TAG_W = 4,
  parameter int CNT_W = 6,
  parameter int QDEPTH = 4,
  parameter int BUF_N = 32,
  parameter int TIMEOUT_CYC = 64,
  parameter logic [7:0] ACK_OP = 8'h78,
  parameter int DEFER_BIT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [TAG_W-1:0]          req_tag,
  input  logic [7:0]                req_op,
  input  logic [CNT_W-1:0]          req_cnt,
  input  logic                      req_defer,
  output logic [7:0]                lut_op,
  input  logic signed [7:0]         lut_send,
  input  logic signed [7:0]         lut_reply,
  output logic [TAG_W-1:0]          dat_tag,
  output logic [CNT_W-1:0]          dat_idx,
  input  logic [7:0]                dat_byte,
  output logic                      link_go,
  output logic                      link_send,
  output logic [7:0]                link_tx,
  input  logic                      link_done,
  input  logic [7:0]                link_rx,
  input  logic                      irq_note,
  output logic                      done,
  output logic [TAG_W-1:0]          done_tag,
  output logic [7:0]                done_len,
  output logic                      done_err,
  output logic                      int_done,
  output logic [7:0]                int_len,
  output logic                      int_err,
  input  logic [$clog2(BUF_N)-1:0]  rd_addr,
  output logic [7:0]                rd_byte
);
  localparam int QW = $clog2(QDEPTH);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_INTACK, S_READ, S_READ_INT} st_t;
  st_t st;

  logic [TAG_W-1:0] q_tag [QDEPTH];
  logic [7:0]       q_op  [QDEPTH];
  logic [CNT_W-1:0] q_cnt [QDEPTH];
  logic             q_def [QDEPTH];
  logic [QW-1:0]    wp, rp;
  logic [QW:0]      qn;

  logic [TAG_W-1:0] c_tag, ptag;
  logic [7:0]       c_op, idx, rlen;
  logic [CNT_W-1:0] c_cnt;
  logic             c_def, hdr, lenb, int_pend, parked, big;
  logic [TW-1:0]    waitc;
  logic [7:0]       rbuf [BUF_N];

  logic push, pop, hv, bad, head_def, tmo, more, wr;
  logic [7:0] rlen_n, idx_n, b0;

  assign req_ready = (qn != (QW+1)'(QDEPTH));
  assign push      = req_valid && req_ready;
  assign hv        = (qn != '0);
  assign head_def  = q_def[rp];
  assign lut_op    = (st == S_IDLE) ? q_op[rp] : c_op;
  assign bad       = !lut_send[7] && (8'(q_cnt[rp]) != 8'(lut_send) + 8'd1);
  assign pop       = (st == S_IDLE) && !int_pend && hv && (bad || !(head_def && parked));
  assign dat_tag   = c_tag;
  assign dat_idx   = idx[CNT_W-1:0];
  assign tmo       = (st != S_IDLE) && !link_done && (waitc == TW'(TIMEOUT_CYC - 1));
  assign rlen_n    = hdr ? link_rx : rlen;
  assign idx_n     = hdr ? idx : idx + 8'd1;
  assign more      = idx_n < rlen_n;
  assign wr        = (st == S_READ || st == S_READ_INT) && link_done && !hdr && (idx < 8'(BUF_N));
  assign b0        = (idx == 8'd0 && !hdr) ? link_rx : rbuf[0];
  assign rd_byte   = rbuf[rd_addr];

  always_ff @(posedge clk)
    if (wr) rbuf[idx[$clog2(BUF_N)-1:0]] <= link_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wp <= '0; rp <= '0; qn <= '0;
      c_tag <= '0; c_op <= '0; c_cnt <= '0; c_def <= 1'b0; ptag <= '0;
      idx <= '0; rlen <= '0; hdr <= 1'b0; lenb <= 1'b0; big <= 1'b0;
      int_pend <= 1'b0; parked <= 1'b0; waitc <= '0;
      link_go <= 1'b0; link_send <= 1'b0; link_tx <= '0;
      done <= 1'b0; done_tag <= '0; done_len <= '0; done_err <= 1'b0;
      int_done <= 1'b0; int_len <= '0; int_err <= 1'b0;
    end else begin
      link_go <= 1'b0; done <= 1'b0; int_done <= 1'b0;
      qn <= qn + (QW+1)'(push) - (QW+1)'(pop);
      if (push) begin
        q_tag[wp] <= req_tag; q_op[wp] <= req_op; q_cnt[wp] <= req_cnt; q_def[wp] <= req_defer;
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      if (st == S_IDLE || link_done) waitc <= '0;
      else waitc <= waitc + 1'b1;

      if (tmo) begin
        st <= S_IDLE;
        if (st == S_SEND || st == S_READ) begin
          done <= 1'b1; done_tag <= c_tag; done_len <= '0; done_err <= 1'b1;
        end else begin
          int_done <= 1'b1; int_len <= '0; int_err <= 1'b1;
        end
      end else case (st)
        S_IDLE:
          if (int_pend) begin
            link_go <= 1'b1; link_send <= 1'b1; link_tx <= ACK_OP;
            int_pend <= 1'b0; st <= S_INTACK;
          end else if (pop && bad) begin
            done <= 1'b1; done_tag <= q_tag[rp]; done_len <= '0; done_err <= 1'b1;
          end else if (pop) begin
            c_tag <= q_tag[rp]; c_op <= q_op[rp]; c_cnt <= q_cnt[rp]; c_def <= head_def;
            link_go <= 1'b1; link_send <= 1'b1; link_tx <= q_op[rp];
            idx <= 8'd1; lenb <= lut_send[7]; st <= S_SEND;
          end
        S_SEND:
          if (link_done) begin
            if (lenb) begin
              link_go <= 1'b1; link_send <= 1'b1; link_tx <= 8'(c_cnt) - 8'd1; lenb <= 1'b0;
            end else if (idx < 8'(c_cnt)) begin
              link_go <= 1'b1; link_send <= 1'b1; link_tx <= dat_byte; idx <= idx + 8'd1;
            end else if (lut_reply == 8'sd0) begin
              st <= S_IDLE;
              if (c_def) begin
                parked <= 1'b1; ptag <= c_tag;
              end else begin
                done <= 1'b1; done_tag <= c_tag; done_len <= '0; done_err <= 1'b0;
              end
            end else begin
              st <= S_READ; idx <= '0; hdr <= lut_reply[7]; rlen <= lut_reply;
              link_go <= 1'b1; link_send <= 1'b0;
            end
          end
        S_INTACK:
          if (link_done) begin
            st <= S_READ_INT; idx <= '0; hdr <= 1'b1; big <= 1'b0;
            link_go <= 1'b1; link_send <= 1'b0;
          end
        default:
          if (link_done) begin
            if (hdr && link_rx > 8'(BUF_N)) big <= 1'b1;
            hdr <= 1'b0; rlen <= rlen_n; idx <= idx_n;
            if (more) begin
              link_go <= 1'b1; link_send <= 1'b0;
            end else begin
              st <= S_IDLE;
              if (st == S_READ) begin
                done <= 1'b1; done_tag <= c_tag; done_len <= idx_n; done_err <= 1'b0;
              end else begin
                int_done <= 1'b1; int_len <= idx_n;
                int_err <= hdr ? (link_rx > 8'(BUF_N)) : big;
                if (parked && idx_n != 8'd0 && b0[DEFER_BIT]) begin
                  parked <= 1'b0;
                  done <= 1'b1; done_tag <= ptag; done_len <= idx_n - 8'd1; done_err <= 1'b0;
                end
              end
            end
          end
      endcase
      if (irq_note) int_pend <= 1'b1;
    end
  end
endmodule

module cmd_seq_chk #(
  parameter logic [7:0] ACK_OP = 8'h78,
  parameter int BUF_N = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       int_pend,
  input logic       hv,
  input logic       head_def,
  input logic       parked,
  input logic       pop,
  input logic       bad,
  input logic       link_go,
  input logic       link_send,
  input logic [7:0] link_tx,
  input logic       done,
  input logic       done_err,
  input logic       int_done,
  input logic [7:0] int_len,
  input logic       int_err
);
  p_ack_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && int_pend) |=> (link_go && link_send && link_tx == ACK_OP));

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && bad && !int_pend) |=> (done && done_err && !link_go));

  p_defer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !int_pend && hv && head_def && parked) |=> !link_go);

  p_big_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_done && int_len > 8'(BUF_N)) |-> int_err);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !int_pend && !hv) |=> !link_go);
endmodule

bind cmd_seq cmd_seq_chk #(.ACK_OP(ACK_OP), .BUF_N(BUF_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .int_pend(int_pend), .hv(hv),
  .head_def(head_def), .parked(parked), .pop(pop), .bad(bad),
  .link_go(link_go), .link_send(link_send), .link_tx(link_tx),
  .done(done), .done_err(done_err), .int_done(int_done),
  .int_len(int_len), .int_err(int_err)
);

// File: tb/cmd_seq_tb.sv
module cmd_seq_tb;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready, req_defer = 0;
  logic [3:0] req_tag = 0;
  logic [7:0] req_op = 0;
  logic [5:0] req_cnt = 0;
  logic [7:0] lut_op;
  logic signed [7:0] lut_send, lut_reply;
  logic [3:0] dat_tag;
  logic [5:0] dat_idx;
  logic [7:0] dat_byte;
  logic link_go, link_send, link_done = 0;
  logic [7:0] link_tx, link_rx = 0;
  logic irq_note = 0;
  logic done, done_err, int_done, int_err;
  logic [3:0] done_tag;
  logic [7:0] done_len, int_len, rd_byte;
  logic [4:0] rd_addr = 0;

  cmd_seq u_dut (.*);

  always_comb begin
    case (lut_op)
      8'h10: begin lut_send = 8'sd2;  lut_reply = 8'sd0;  end
      8'h20: begin lut_send = -8'sd1; lut_reply = 8'sd0;  end
      8'h30: begin lut_send = 8'sd1;  lut_reply = 8'sd3;  end
      8'h40: begin lut_send = 8'sd0;  lut_reply = -8'sd1; end
      8'h50: begin lut_send = -8'sd1; lut_reply = 8'sd0;  end
      default: begin lut_send = 8'sd0; lut_reply = 8'sd0; end
    endcase
  end
  assign dat_byte = {dat_tag, dat_idx[3:0]};

  logic resp_en = 1;
  int pend_c = 0, txn = 0, rxp = 0, rxn = 0;
  logic [7:0] txlog [256];
  logic [7:0] rxq [256];
  always @(negedge clk) begin
    link_done <= 0;
    if (pend_c > 0) begin
      pend_c <= pend_c - 1;
      if (pend_c == 1) link_done <= 1;
    end
    if (rst_n && link_go && resp_en) begin
      pend_c <= 2;
      if (link_send) begin txlog[txn] <= link_tx; txn <= txn + 1; end
      else begin link_rx <= rxq[rxp]; rxp <= rxp + 1; rxn <= rxn + 1; end
    end
  end

  int dn = 0, inn = 0;
  logic [3:0] dtag [64];
  logic [7:0] dlen [64], ilen [64];
  logic derr [64], ierr [64];
  always @(negedge clk) begin
    if (done) begin dtag[dn] <= done_tag; dlen[dn] <= done_len; derr[dn] <= done_err; dn <= dn + 1; end
    if (int_done) begin ilen[inn] <= int_len; ierr[inn] <= int_err; inn <= inn + 1; end
  end

  int nchk = 0, nfail = 0, cyc = 0;
  bit fin = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !fin) begin
      fin = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", rq, act, exp); end
  endtask
  task automatic eq(input string rq, input int act, input int exp);
    chk(act == exp, rq, act, exp);
  endtask

  task automatic push(input logic [3:0] t, input logic [7:0] op, input logic [5:0] c, input logic d, input bit irq);
    @(negedge clk);
    req_valid = 1; req_tag = t; req_op = op; req_cnt = c; req_defer = d; irq_note = irq;
    @(negedge clk);
    req_valid = 0; irq_note = 0;
  endtask
  task automatic pulse_irq();
    @(negedge clk); irq_note = 1; @(negedge clk); irq_note = 0;
  endtask
  task automatic wait_cnt(ref int ctr, input int n);
    for (int i = 0; i < 3000 && ctr < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask
  task automatic rbyte(input int a, output logic [7:0] v);
    rd_addr = 5'(a); #1 v = rd_byte;
  endtask

  task automatic t_reset();
    eq("R1 ready", req_ready, 1);
    eq("R1 go", link_go, 0);
    eq("R1 done", done | int_done, 0);
    repeat (5) @(negedge clk);
    eq("R1 quiet link", txn, 0);
  endtask

  task automatic t_fixed_send();
    int b = txn, d = dn, r = rxn;
    push(1, 8'h10, 3, 0, 0); wait_cnt(dn, d + 1);
    eq("R2 bytes", txn - b, 3);
    eq("R2 op", txlog[b], 8'h10);
    eq("R2 d1", txlog[b+1], 8'h11);
    eq("R2 d2", txlog[b+2], 8'h12);
    eq("R7 tag", dtag[d], 1);
    eq("R7 len/err", {dlen[d], 7'd0, derr[d]}, 0);
    eq("R7 no rx", rxn - r, 0);
  endtask

  task automatic t_var_send();
    int b = txn, d = dn;
    push(2, 8'h20, 4, 0, 0); wait_cnt(dn, d + 1);
    eq("R3 bytes", txn - b, 5);
    eq("R3 op", txlog[b], 8'h20);
    eq("R3 lenbyte", txlog[b+1], 3);
    eq("R3 d1", txlog[b+2], 8'h21);
    eq("R3 d3", txlog[b+4], 8'h23);
  endtask

  task automatic t_reject();
    int b = txn, d = dn;
    push(9, 8'h10, 2, 0, 0); wait_cnt(dn, d + 1);
    eq("R4 no link", txn - b, 0);
    eq("R4 err", derr[d], 1);
    eq("R4 tag", dtag[d], 9);
    eq("R4 len", dlen[d], 0);
  endtask

  task automatic t_fixed_reply();
    int b = txn, d = dn, r = rxn;
    logic [7:0] v;
    rxq[rxp] = 8'hA1; rxq[rxp+1] = 8'hA2; rxq[rxp+2] = 8'hA3;
    push(3, 8'h30, 2, 0, 0); wait_cnt(dn, d + 1);
    eq("R5 sent", txn - b, 2);
    eq("R5 rx count", rxn - r, 3);
    eq("R5 len", dlen[d], 3);
    rbyte(0, v); eq("R5 b0", v, 8'hA1);
    rbyte(2, v); eq("R5 b2", v, 8'hA3);
  endtask

  task automatic t_var_reply();
    int d = dn;
    logic [7:0] v;
    rxq[rxp] = 2; rxq[rxp+1] = 8'hB1; rxq[rxp+2] = 8'hB2;
    push(4, 8'h40, 1, 0, 0); wait_cnt(dn, d + 1);
    eq("R6 len", dlen[d], 2);
    rbyte(0, v); eq("R6 b0", v, 8'hB1);
    rbyte(1, v); eq("R6 b1", v, 8'hB2);
  endtask

  task automatic t_irq();
    int b = txn, d = dn, i = inn;
    logic [7:0] v;
    rxq[rxp] = 1; rxq[rxp+1] = 8'h05;
    push(5, 8'h10, 3, 0, 1); wait_cnt(dn, d + 1);
    eq("R8 ack first", txlog[b], 8'h78);
    eq("R8 req after", txlog[b+1], 8'h10);
    eq("R8 int count", inn - i, 1);
    eq("R8 int len", ilen[i], 1);
    eq("R8 int err", ierr[i], 0);
    rbyte(0, v); eq("R8 payload", v, 8'h05);
  endtask

  task automatic t_big();
    int i = inn;
    logic [7:0] v;
    rxq[rxp] = 40;
    for (int k = 0; k < 40; k++) rxq[rxp+1+k] = 8'(8'hC0 + k);
    pulse_irq(); wait_cnt(inn, i + 1);
    eq("R9 len", ilen[i], 40);
    eq("R9 err", ierr[i], 1);
    rbyte(0, v); eq("R9 b0 kept", v, 8'hC0);
    rbyte(31, v); eq("R9 b31", v, 8'hDF);
  endtask

  task automatic t_defer();
    int b = txn, d = dn, i = inn;
    push(6, 8'h50, 2, 1, 0);
    push(7, 8'h50, 1, 1, 0);
    repeat (60) @(negedge clk);
    eq("R10 first sent", txn - b, 3);
    eq("R10 lenbyte", txlog[b+1], 1);
    eq("R10 no done", dn - d, 0);
    rxq[rxp] = 3; rxq[rxp+1] = 8'h10; rxq[rxp+2] = 8'hD1; rxq[rxp+3] = 8'hD2;
    pulse_irq(); wait_cnt(dn, d + 1);
    eq("R10 deliver tag", dtag[d], 6);
    eq("R10 deliver len", dlen[d], 2);
    repeat (30) @(negedge clk);
    eq("R10 second op", txlog[b+4], 8'h50);
    eq("R10 second len", txlog[b+5], 0);
    rxq[rxp] = 1; rxq[rxp+1] = 8'h10;
    pulse_irq(); wait_cnt(dn, d + 2);
    eq("R10 second tag", dtag[d+1], 7);
    eq("R10 second rlen", dlen[d+1], 0);
  endtask

  task automatic t_timeout();
    int d = dn, b;
    resp_en = 0;
    push(8, 8'h10, 3, 0, 0); wait_cnt(dn, d + 1);
    eq("R11 abort err", derr[d], 1);
    eq("R11 abort tag", dtag[d], 8);
    resp_en = 1;
    b = txn;
    push(10, 8'h10, 3, 0, 0); wait_cnt(dn, d + 2);
    eq("R11 recover", {derr[d+1], 3'd0, dtag[d+1]}, 10);
    eq("R11 recover bytes", txn - b, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fixed_send();
    t_var_send();
    t_reject();
    t_fixed_reply();
    t_var_reply();
    t_irq();
    t_big();
    t_defer();
    t_timeout();
    if (!fin) begin
      fin = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule